// File: doc/BRIEF.md
# Two-Wire Configuration Register Bank

This block is the slave side of a small configuration port for a voltage-regulator controller. A host reaches it over a two-wire serial bus (clock and open-drain data) with I2C-style framing: a START, an address byte whose least significant bit selects read or write, an acknowledge, then bytes. A write sends a register index and then data bytes. A read returns bytes starting at the current index. A strap input picks one of two device addresses.

The bank holds a 5-bit output-offset code. Its millivolt value is also decoded onto a port. The bank also holds a live copy of a sensed load-current word, a control/status byte and a fixed revision byte. Two status bits are sticky and can only be cleared by software writing zero. Two events restore defaults. A socket-change input restores every register. A low pulse on the regulator's reset line restores every register except the control/status byte, but only while the watchdog enable bit is set. The serial clock, serial data and both event inputs are sampled through a synchronizer on the system clock. The system clock must run at least about eight times faster than the serial clock.

Top module: `cfg_bank`

## Requirements
- R1: With `addr_sel_i`=1 the address byte 0x5E (write) or 0x5F (read) is acknowledged. With `addr_sel_i`=0 the bytes 0x5C/0x5D are acknowledged. Any other address gets no acknowledge, and the data line stays released until the next START.
- R2: In a write, the first byte after the address is the register index. Each following data byte is written at the index, and the index then advances by one.
- R3: In a read, bytes come most significant bit first, starting at the current index. The index advances after each byte. A master ACK (data low) requests the next byte, and a NACK ends the transfer.
- R4: Index 0x00 holds the offset code in bits 4:0, drives `vid_ofs_o`, reads 0 in bits 7:5, and resets to 0. It changes only on a bus write or a default-restoring event.
- R5: `ofs_mv_o` is 25 times the offset code in mV, except that code 31 gives 800.
- R6: Index 0x01 reads the sampled `load_cur_i` in bits 6:0 and ignores writes.
- R7: Index 0x03 bit 0 is the watchdog enable. It is read/write and drives `wd_en_o`. Index 0x03 resets to 0x04.
- R8: Index 0x03 bit 2 (socket event seen) and bit 1 (reset line pulsed while enabled) clear when 0 is written and keep their value when 1 is written. Bits 7:3 read 0.
- R9: While `socket_i` is high, all registers return to defaults: offset 0, and index 0x03 = 0x04.
- R10: While `rst_line_ni` is low and bit 0 of index 0x03 is 1, the offset returns to 0 and bit 1 of index 0x03 sets. Bits 0 and 2 keep their values. With bit 0 clear, the line has no effect.
- R11: Index 0x13 reads 0x00. Unimplemented indices read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 1 | Address strap, selects 0x5E or 0x5C |
| socket_i | input | 1 | Socket-change event, active high |
| rst_line_ni | input | 1 | Regulator reset line, active low |
| load_cur_i | input | 7 | Sensed load current, full scale at the trip point |
| vid_ofs_o | output | 5 | Offset code |
| ofs_mv_o | output | 10 | Offset in millivolts |
| wd_en_o | output | 1 | Watchdog reset generator enable |

## Verification
Every pin passes through two synchronizer stages and one edge register. A bus edge therefore acts three system clocks after it appears, and a register write lands one clock after that. `ofs_mv_o` follows the stored code combinationally. The socket and reset-line events change registers three clocks after the pin moves. The bench moves the serial clock only after quarter periods of eight system clocks. It samples the data line in the middle of the high phase, and it reads ports on falling clock edges at least six clocks after an event. Every expected value is therefore settled before it is read.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  typedef enum logic [2:0] {
    L_IDLE, L_ADDR, L_IDX, L_DATA, L_ACK, L_TX, L_MACK
  } link_st_e;

  localparam logic [7:0] IDX_OFS  = 8'h00;
  localparam logic [7:0] IDX_CUR  = 8'h01;
  localparam logic [7:0] IDX_MISC = 8'h03;
  localparam logic [7:0] IDX_REV  = 8'h13;

  // bit2: socket seen, bit1: line pulsed, bit0: watchdog enable
  localparam logic [2:0] MISC_DEF = 3'b100;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= d_i;
      else             stg[g] <= stg[(g > 0) ? g - 1 : 0];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cfg_link.sv
module cfg_link
  import cfg_bank_pkg::*;
#(
  parameter logic [6:0] DEV_HI = 7'h2F,
  parameter logic [6:0] DEV_LO = 7'h2E
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] rd_idx_o,
  output logic       wr_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wdata_o,
  output logic       sda_oe_o
);
  link_st_e   st, after;
  logic       scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sh, tx, idx;
  logic       mack;
  logic [6:0] dev;

  wire rise  = scl_i & ~scl_q;
  wire fall  = ~scl_i & scl_q;
  wire start = scl_i & scl_q & sda_q & ~sda_i;
  wire stop  = scl_i & scl_q & ~sda_q & sda_i;

  assign dev      = addr_sel_i ? DEV_HI : DEV_LO;
  assign rd_idx_o = idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= L_IDLE;
      after    <= L_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      idx      <= '0;
      mack     <= 1'b0;
      wr_o     <= 1'b0;
      wr_idx_o <= '0;
      wdata_o  <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      wr_o  <= 1'b0;
      if (start) begin
        st       <= L_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop) begin
        st       <= L_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          L_ADDR, L_IDX, L_DATA: begin
            if (rise) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == L_ADDR) begin
                if (sh[7:1] == dev) begin
                  sda_oe_o <= 1'b1;
                  st       <= L_ACK;
                  after    <= sh[0] ? L_TX : L_IDX;
                end else begin
                  st <= L_IDLE;
                end
              end else if (st == L_IDX) begin
                idx      <= sh;
                sda_oe_o <= 1'b1;
                st       <= L_ACK;
                after    <= L_DATA;
              end else begin
                wr_o     <= 1'b1;
                wr_idx_o <= idx;
                wdata_o  <= sh;
                idx      <= idx + 8'd1;
                sda_oe_o <= 1'b1;
                st       <= L_ACK;
                after    <= L_DATA;
              end
            end
          end
          L_ACK: begin
            if (fall) begin
              st  <= after;
              cnt <= '0;
              if (after == L_TX) begin
                tx       <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
              end else begin
                sda_oe_o <= 1'b0;
              end
            end
          end
          L_TX: begin
            if (fall) begin
              if (cnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                idx      <= idx + 8'd1;
                st       <= L_MACK;
              end else begin
                tx       <= {tx[6:0], 1'b0};
                sda_oe_o <= ~tx[6];
                cnt      <= cnt + 4'd1;
              end
            end
          end
          L_MACK: begin
            if (rise) begin
              mack <= ~sda_i;
            end else if (fall) begin
              if (mack) begin
                tx       <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                cnt      <= '0;
                st       <= L_TX;
              end else begin
                st <= L_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_bank_pkg::*;
#(
  parameter int         VID_W  = 5,
  parameter int         CUR_W  = 7,
  parameter logic [7:0] REV_ID = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wr_idx_i,
  input  logic [7:0]       wdata_i,
  input  logic [7:0]       rd_idx_i,
  output logic [7:0]       rd_data_o,
  input  logic [CUR_W-1:0] load_cur_i,
  input  logic             sock_i,
  input  logic             line_low_i,
  output logic             wd_hit_o,
  output logic [VID_W-1:0] vid_o,
  output logic [2:0]       misc_o
);
  logic [VID_W-1:0] vid;
  logic [CUR_W-1:0] cur;
  logic [2:0]       misc;
  logic             unused_w;

  assign wd_hit_o = line_low_i & misc[0];
  assign unused_w = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid  <= '0;
      cur  <= '0;
      misc <= MISC_DEF;
    end else if (sock_i) begin
      vid  <= '0;
      cur  <= '0;
      misc <= MISC_DEF;
    end else if (wd_hit_o) begin
      vid     <= '0;
      cur     <= '0;
      misc[1] <= 1'b1;
    end else begin
      cur <= load_cur_i;
      if (wr_i) begin
        if (wr_idx_i == IDX_OFS)  vid  <= wdata_i[VID_W-1:0];
        if (wr_idx_i == IDX_MISC) misc <= {misc[2] & wdata_i[2], misc[1] & wdata_i[1], wdata_i[0]};
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_idx_i)
      IDX_OFS:  rd_data_o[VID_W-1:0] = vid;
      IDX_CUR:  rd_data_o[CUR_W-1:0] = cur;
      IDX_MISC: rd_data_o[2:0]       = misc;
      IDX_REV:  rd_data_o            = REV_ID;
      default:  rd_data_o            = '0;
    endcase
  end

  assign vid_o  = vid;
  assign misc_o = misc;
endmodule

// File: rtl/cfg_ofs_map.sv
module cfg_ofs_map #(
  parameter int VID_W   = 5,
  parameter int MV_W    = 10,
  parameter int STEP_MV = 25,
  parameter int TOP_MV  = 800
) (
  input  logic [VID_W-1:0] code_i,
  output logic [MV_W-1:0]  mv_o
);
  // all-ones code jumps past the linear step
  assign mv_o = (&code_i) ? MV_W'(TOP_MV) : MV_W'(code_i) * MV_W'(STEP_MV);
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_bank_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_HI      = 7'h2F,
  parameter logic [6:0] DEV_LO      = 7'h2E,
  parameter int         VID_W       = 5,
  parameter int         CUR_W       = 7,
  parameter int         MV_W        = 10,
  parameter int         STEP_MV     = 25,
  parameter int         TOP_MV      = 800,
  parameter logic [7:0] REV_ID      = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             addr_sel_i,
  input  logic             socket_i,
  input  logic             rst_line_ni,
  input  logic [CUR_W-1:0] load_cur_i,
  output logic [VID_W-1:0] vid_ofs_o,
  output logic [MV_W-1:0]  ofs_mv_o,
  output logic             wd_en_o
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] sync_q;
  logic       scl_s, sda_s, sock_s, line_s;
  logic       lnk_wr;
  logic [7:0] lnk_wr_idx, lnk_wdata, lnk_rd_idx, rd_data;
  logic       wd_hit;
  logic [2:0] misc_q;

  cfg_sync #(
    .W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b1011)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rst_line_ni, socket_i, sda_i, scl_i}),
    .q_o   (sync_q)
  );

  assign scl_s  = sync_q[0];
  assign sda_s  = sync_q[1];
  assign sock_s = sync_q[2];
  assign line_s = sync_q[3];

  cfg_link #(.DEV_HI(DEV_HI), .DEV_LO(DEV_LO)) u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .addr_sel_i(addr_sel_i),
    .rd_data_i (rd_data),
    .rd_idx_o  (lnk_rd_idx),
    .wr_o      (lnk_wr),
    .wr_idx_o  (lnk_wr_idx),
    .wdata_o   (lnk_wdata),
    .sda_oe_o  (sda_oe_o)
  );

  cfg_regs #(.VID_W(VID_W), .CUR_W(CUR_W), .REV_ID(REV_ID)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (lnk_wr),
    .wr_idx_i  (lnk_wr_idx),
    .wdata_i   (lnk_wdata),
    .rd_idx_i  (lnk_rd_idx),
    .rd_data_o (rd_data),
    .load_cur_i(load_cur_i),
    .sock_i    (sock_s),
    .line_low_i(~line_s),
    .wd_hit_o  (wd_hit),
    .vid_o     (vid_ofs_o),
    .misc_o    (misc_q)
  );

  cfg_ofs_map #(
    .VID_W(VID_W), .MV_W(MV_W), .STEP_MV(STEP_MV), .TOP_MV(TOP_MV)
  ) u_map (
    .code_i(vid_ofs_o),
    .mv_o  (ofs_mv_o)
  );

  assign wd_en_o = misc_q[0];
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk #(
  parameter int VID_W  = 5,
  parameter int MV_W   = 10,
  parameter int TOP_MV = 800
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             sock_i,
  input logic             wd_i,
  input logic [VID_W-1:0] vid_i,
  input logic [2:0]       misc_i,
  input logic [MV_W-1:0]  mv_i
);
  assert_vid_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !sock_i && !wd_i) |=> $stable(vid_i));

  assert_sock_default_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sock_i |=> (vid_i == '0 && misc_i == 3'b100));

  assert_sock_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sock_i |=> !$rose(misc_i[2]));

  assert_line_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_i |=> !$rose(misc_i[1]));

  assert_mv_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_i <= MV_W'(TOP_MV));
endmodule

bind cfg_bank cfg_bank_chk #(.VID_W(VID_W), .MV_W(MV_W), .TOP_MV(TOP_MV)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .wr_i  (lnk_wr),
  .sock_i(sock_s),
  .wd_i  (wd_hit),
  .vid_i (vid_ofs_o),
  .misc_i(misc_q),
  .mv_i  (ofs_mv_o)
);

// File: tb/cfg_bank_bench.sv
module cfg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WD_CYCLES  = 190000;
  localparam int N_VEC      = 9;
  // {index, write data, expected read}
  localparam logic [23:0] VEC [N_VEC] = '{
    24'h00_15_15, 24'h00_FF_1F, 24'h13_AA_00, 24'h07_55_00, 24'h01_7F_2A,
    24'h03_07_05, 24'h03_01_01, 24'h03_04_00, 24'h00_00_00
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mst_scl = 1'b1, mst_sda = 1'b1;
  logic       addr_sel = 1'b1, socket = 1'b0, line_n = 1'b1;
  logic [6:0] load_cur = 7'h2A;
  logic       sda_oe;
  logic [4:0] vid;
  logic [9:0] mv;
  logic       wd_en;
  wire        sda_line = mst_sda & ~sda_oe;
  int         total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_bank u_cfg_bank (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(mst_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .socket_i(socket),
    .rst_line_ni(line_n), .load_cur_i(load_cur), .vid_ofs_o(vid),
    .ofs_mv_o(mv), .wd_en_o(wd_en)
  );

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_start;
    mst_sda = 1'b1; wq(Q); mst_scl = 1'b1; wq(Q);
    mst_sda = 1'b0; wq(Q); mst_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    mst_sda = 1'b0; wq(Q); mst_scl = 1'b1; wq(Q); mst_sda = 1'b1; wq(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mst_sda = b[i]; wq(Q); mst_scl = 1'b1; wq(Q); mst_scl = 1'b0; wq(2);
    end
    mst_sda = 1'b1; wq(Q); mst_scl = 1'b1; wq(Q/2);
    ack = (sda_line == 1'b0);
    wq(Q/2); mst_scl = 1'b0; wq(Q);
  endtask

  task automatic recv(input logic ack_in, output logic [7:0] b);
    b = '0;
    mst_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(Q); mst_scl = 1'b1; wq(Q/2);
      b = {b[6:0], sda_line};
      wq(Q/2); mst_scl = 1'b0; wq(2);
    end
    mst_sda = ack_in ? 1'b0 : 1'b1;
    wq(Q); mst_scl = 1'b1; wq(Q); mst_scl = 1'b0; wq(2);
    mst_sda = 1'b1; wq(Q);
  endtask

  function automatic logic [7:0] dev_w();
    return addr_sel ? 8'h5E : 8'h5C;
  endfunction

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    logic a;
    bus_start; send(dev_w(), a); send(idx, a); send(d, a); bus_stop;
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [7:0] d);
    logic a;
    bus_start; send(dev_w(), a); send(idx, a);
    bus_start; send(dev_w() | 8'h01, a); recv(1'b0, d); bus_stop;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic       a;
    wq(5); rst_n = 1'b1; wq(5);

    // reset state R4 R7
    chk("R4 reset vid", 16'(vid), 16'h0);
    chk("R5 reset mv", 16'(mv), 16'd0);
    chk("R7 reset wd_en", 16'(wd_en), 16'h0);
    rd_reg(8'h03, d); chk("R7 reset misc", 16'(d), 16'h04);
    rd_reg(8'h00, d); chk("R4 reset ofs", 16'(d), 16'h00);

    // table walk: R4 R6 R8 R11
    for (int k = 0; k < N_VEC; k++) begin
      wr_reg(VEC[k][23:16], VEC[k][15:8]);
      rd_reg(VEC[k][23:16], d);
      chk($sformatf("R4 R6 R8 R11 vector %0d", k), 16'(d), 16'(VEC[k][7:0]));
    end

    // R1 address match
    bus_start; send(8'h5C, a); chk("R1 wrong addr nack", 16'(a), 16'h0);
    send(8'h00, a); chk("R1 released after mismatch", 16'(a), 16'h0);
    bus_stop;
    addr_sel = 1'b0;
    wr_reg(8'h00, 8'h07);
    rd_reg(8'h00, d); chk("R1 low strap access", 16'(d), 16'h07);
    bus_start; send(8'h5E, a); chk("R1 high addr nack on low strap", 16'(a), 16'h0);
    bus_stop;
    addr_sel = 1'b1;
    bus_start; send(8'h5E, a); chk("R1 high addr ack", 16'(a), 16'h1);
    bus_stop;

    // R2 burst write across indices 0..3
    bus_start; send(8'h5E, a); send(8'h00, a);
    send(8'h03, a); send(8'h09, a); send(8'h77, a); send(8'h01, a);
    bus_stop; wq(8);
    chk("R2 burst first byte", 16'(vid), 16'h03);
    chk("R2 burst fourth byte wd_en", 16'(wd_en), 16'h1);

    // R3 burst read
    bus_start; send(8'h5E, a); send(8'h00, a);
    bus_start; send(8'h5F, a);
    recv(1'b1, d); chk("R3 read idx0", 16'(d), 16'h03);
    recv(1'b1, d); chk("R3 read idx1", 16'(d), 16'h2A);
    recv(1'b1, d); chk("R3 read idx2", 16'(d), 16'h00);
    recv(1'b0, d); chk("R3 read idx3", 16'(d), 16'h01);
    bus_stop; wq(4);
    chk("R3 line released after nack", 16'(sda_oe), 16'h0);

    // R5 offset map
    wr_reg(8'h00, 8'h1F); wq(4); chk("R5 code 31", 16'(mv), 16'd800);
    wr_reg(8'h00, 8'h1E); wq(4); chk("R5 code 30", 16'(mv), 16'd750);
    wr_reg(8'h00, 8'h01); wq(4); chk("R5 code 1", 16'(mv), 16'd25);

    // R10 reset line while enabled
    wr_reg(8'h00, 8'h0A);
    line_n = 1'b0; wq(6); line_n = 1'b1; wq(6);
    chk("R10 ofs cleared", 16'(vid), 16'h0);
    chk("R10 wd_en kept", 16'(wd_en), 16'h1);
    rd_reg(8'h03, d); chk("R10 misc flag", 16'(d), 16'h03);
    wr_reg(8'h03, 8'h03); rd_reg(8'h03, d); chk("R8 write one keeps bit1", 16'(d), 16'h03);
    wr_reg(8'h03, 8'h01); rd_reg(8'h03, d); chk("R8 write zero clears bit1", 16'(d), 16'h01);
    wr_reg(8'h03, 8'h00);
    wr_reg(8'h00, 8'h0A);
    line_n = 1'b0; wq(6); line_n = 1'b1; wq(6);
    chk("R10 disabled no effect", 16'(vid), 16'h0A);
    rd_reg(8'h03, d); chk("R10 disabled misc", 16'(d), 16'h00);

    // R9 socket event
    wr_reg(8'h03, 8'h01); wr_reg(8'h00, 8'h05);
    socket = 1'b1; wq(6); socket = 1'b0; wq(6);
    chk("R9 ofs default", 16'(vid), 16'h0);
    chk("R9 wd_en default", 16'(wd_en), 16'h0);
    rd_reg(8'h03, d); chk("R9 misc default", 16'(d), 16'h04);

    // R6 current register
    load_cur = 7'h7F; wq(4);
    rd_reg(8'h01, d); chk("R6 current full", 16'(d), 16'h7F);
    wr_reg(8'h01, 8'h00);
    rd_reg(8'h01, d); chk("R6 write ignored", 16'(d), 16'h7F);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule